// File: doc/BRIEF.md
# Doubleword Memory with Sub-word Access

This block is a synchronous on-chip memory whose storage unit is a 64-bit doubleword, addressed by byte. A request carries a byte address, a two-bit size code, a write flag and store data. The upper address bits pick the doubleword. The low three bits pick where inside it the access sits. Loads and stores of one, two, four or eight bytes are supported. Byte lanes are numbered from the most-significant end of the doubleword: offset 0 is the top byte.

A narrow store merges its lane into the stored doubleword by read-modify-write within the same cycle and leaves the other bytes alone. A narrow load returns its lane right-justified and zero-extended. A per-word written flag is cleared on reset, so a word that has not been stored since reset reads as zero. Any access whose offset is not a multiple of its size is rejected. It raises an error flag one cycle later and leaves the memory unchanged.

Top module: `dw_subword_mem`

## Requirements
- R1: The doubleword index is the byte address shifted right by 3, and the offset is address bits [2:0]. Words with different indices are independent of each other.
- R2: The size code selects the access width: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 is 4 bytes and 2'b11 is 8 bytes. An access is legal only when the offset is a multiple of that width.
- R3: An illegal request raises `rsp_misalign` for exactly the next cycle and never raises `rsp_valid`. An illegal store does not change any stored byte.
- R4: `rsp_valid` is high in the cycle after a legal load and is low otherwise. `rsp_misalign` is low except after an illegal request. `rsp_data` is zero whenever `rsp_valid` is low, including in reset.
- R5: An access of n bytes at offset k covers stored bits [63-8k -: 8n]. Offset 0 is the most-significant byte.
- R6: A load of fewer than 8 bytes returns its lane in `rsp_data[8n-1:0]` with all upper bits zero.
- R7: A store of fewer than 8 bytes replaces only its lane. Store data bits at and above 8n are ignored.
- R8: An 8-byte store replaces the whole doubleword.
- R9: A word that has not been stored since the last reset reads as zero. A narrow store into such a word merges into zero.
- R10: A load issued in the cycle right after a store to the same word returns the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the written flags and the response |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (R2) |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | Load data valid (one cycle after the load) |
| rsp_data | output | 64 | Load data, zero-extended |
| rsp_misalign | output | 1 | Previous request was misaligned and was dropped |

## Verification
The first pattern fills one doubleword with distinct bytes and reads it back at every legal width and offset. Because each byte is unique, a reversed lane order or a wrong shift shows up as a different value. Narrow stores with all-ones upper data separate a correct lane mask from one that leaks outside the lane, and stores into fresh words show whether the merge starts from zero. Misaligned requests of every size are each followed by a full read of the targeted word, which exposes any write that slipped through. A long run of mixed random operations over a few words, plus a reset in the middle, is compared every cycle against a byte-level reference model.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_DBL  = 2'b11
   } size_e;

   function automatic int unsigned size_bytes(input logic [1:0] code);
      return 32'd1 << code;
   endfunction

endpackage

// File: rtl/dwm_align_chk.sv
module dwm_align_chk #(
   parameter int BYTES = 8
) (
   input  logic [$clog2(BYTES)-1:0] off,
   input  logic [1:0]               size,
   output logic                     legal,
   output logic [$clog2(BYTES*8):0] shift,
   output logic [BYTES*8-1:0]       lane_mask,
   output logic [BYTES*8-1:0]       data_mask
);
   import dwm_pkg::*;

   localparam int DATA_W = BYTES * 8;
   localparam int OFF_W  = $clog2(BYTES);
   localparam int SH_W   = $clog2(DATA_W) + 1;

   logic [OFF_W:0]      nbytes;
   logic [OFF_W:0]      span;
   logic [DATA_W-1:0]   dmask;

   always_comb begin
      nbytes = (OFF_W+1)'(size_bytes(size));
      legal  = ((off & OFF_W'(nbytes - 1'b1)) == '0);
      span   = (OFF_W+1)'(BYTES) - nbytes - {1'b0, off};
      shift  = legal ? SH_W'({span, 3'b000}) : '0;
      dmask  = '0;
      for (int b = 0; b < BYTES; b++) begin
         if (b < int'(nbytes)) dmask[b*8 +: 8] = 8'hFF;
      end
      data_mask = dmask;
      lane_mask = legal ? (dmask << shift) : '0;
   end

endmodule

// File: rtl/dwm_lane_unit.sv
module dwm_lane_unit #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]        word_in,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(DATA_W):0]  shift,
   input  logic [DATA_W-1:0]        lane_mask,
   input  logic [DATA_W-1:0]        data_mask,
   output logic [DATA_W-1:0]        load_val,
   output logic [DATA_W-1:0]        merged
);

   logic [DATA_W-1:0] placed;

   always_comb begin
      load_val = (word_in & lane_mask) >> shift;
      placed   = (wdata & data_mask) << shift;
      merged   = (word_in & ~lane_mask) | placed;
   end

endmodule

// File: rtl/dwm_store.sv
module dwm_store #(
   parameter int WORDS  = 32,
   parameter int DATA_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(WORDS)-1:0] idx,
   output logic [DATA_W-1:0]        rd_word,
   input  logic                     we,
   input  logic [DATA_W-1:0]        wr_word
);

   localparam int IDX_W = $clog2(WORDS);

   logic [DATA_W-1:0] mem [WORDS];
   logic [WORDS-1:0]  written;

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wr_word;
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                            written[w] <= 1'b0;
         else if (we && idx == IDX_W'(w))       written[w] <= 1'b1;
      end
   end

   assign rd_word = written[idx] ? mem[idx] : '0;

   // a write must leave its word marked as written
   AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> written[$past(idx)]);  // R9

endmodule

// File: rtl/dw_subword_mem.sv
module dw_subword_mem #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [63:0]       req_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_data,
   output logic              rsp_misalign
);

   localparam int DATA_W = BYTES * 8;
   localparam int OFF_W  = $clog2(BYTES);
   localparam int IDX_W  = ADDR_W - OFF_W;
   localparam int WORDS  = 1 << IDX_W;
   localparam int SH_W   = $clog2(DATA_W) + 1;

   if (BYTES != 8) begin : g_bad_bytes
      $error("dw_subword_mem: BYTES must be 8 for a 2-bit size code");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_addr
      $error("dw_subword_mem: ADDR_W gives an unsupported depth");
   end

   logic [IDX_W-1:0]  idx;
   logic [OFF_W-1:0]  off;
   logic              legal;
   logic [SH_W-1:0]   shift;
   logic [DATA_W-1:0] lane_mask, data_mask;
   logic [DATA_W-1:0] cur_word, load_val, merged;
   logic              st_we, ld_ok;

   assign idx = req_addr[ADDR_W-1:OFF_W];
   assign off = req_addr[OFF_W-1:0];

   dwm_align_chk #(.BYTES(BYTES)) u_align (
      .off       (off),
      .size      (req_size),
      .legal     (legal),
      .shift     (shift),
      .lane_mask (lane_mask),
      .data_mask (data_mask)
   );

   dwm_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (idx),
      .rd_word (cur_word),
      .we      (st_we),
      .wr_word (merged)
   );

   dwm_lane_unit #(.DATA_W(DATA_W)) u_lane (
      .word_in   (cur_word),
      .wdata     (req_wdata),
      .shift     (shift),
      .lane_mask (lane_mask),
      .data_mask (data_mask),
      .load_val  (load_val),
      .merged    (merged)
   );

   assign st_we = req_valid &  req_write & legal;
   assign ld_ok = req_valid & ~req_write & legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_misalign <= 1'b0;
         rsp_data     <= '0;
      end else begin
         rsp_valid    <= ld_ok;
         rsp_misalign <= req_valid & ~legal;
         rsp_data     <= ld_ok ? load_val : '0;
      end
   end

   AST_MISALIGN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_misalign |-> !rsp_valid);  // R3
   AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && legal) |=> rsp_valid);  // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_misalign && rsp_data == '0));  // R4
   AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_size) == 2'b00) |-> rsp_data[63:8] == '0);  // R6
   AST_LANE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      legal |-> $countones(lane_mask) == (8 << req_size));  // R5

endmodule

// File: tb/dw_subword_mem_bench.sv
module dw_subword_mem_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic        rsp_misalign;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [63:0] model [int];
   logic        exp_valid = 1'b0;
   logic [63:0] exp_data  = '0;
   logic        exp_err   = 1'b0;
   string       exp_tag   = "R4";

   always #2 clk = ~clk;

   dw_subword_mem u_dw_subword_mem (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_size     (req_size),
      .req_wdata    (req_wdata),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_misalign (rsp_misalign)
   );

   function automatic logic [63:0] word_of(input int i);
      return model.exists(i) ? model[i] : 64'd0;
   endfunction

   task automatic compare();
      total++;
      if (rsp_valid !== exp_valid || rsp_data !== exp_data || rsp_misalign !== exp_err) begin
         bad++;
         $display("FAIL %s: got valid=%b data=%h err=%b, expected valid=%b data=%h err=%b",
                  exp_tag, rsp_valid, rsp_data, rsp_misalign, exp_valid, exp_data, exp_err);
      end
   endtask

   // compare last cycle's response, then present a new request and predict it
   task automatic issue(input bit v, input bit w, input logic [7:0] a,
                        input logic [1:0] sz, input logic [63:0] d, input string tag);
      int n, off, wi;
      logic [63:0] word, res;
      @(negedge clk);
      compare();
      req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
      n = 1 << sz; off = a % 8; wi = a / 8;
      exp_tag = tag; exp_valid = 1'b0; exp_data = '0; exp_err = 1'b0;
      if (v) begin
         if (off % n != 0) exp_err = 1'b1;
         else begin
            word = word_of(wi);
            res = '0;
            for (int j = 0; j < n; j++) begin
               if (w) word[63-8*(off+j) -: 8] = d[8*(n-1-j) +: 8];
               else   res[8*(n-1-j) +: 8]     = word[63-8*(off+j) -: 8];
            end
            if (w) model[wi] = word;
            else begin exp_valid = 1'b1; exp_data = res; end
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      compare();
      rst_n = 1'b0; req_valid = 1'b0;
      exp_valid = 1'b0; exp_data = '0; exp_err = 1'b0; exp_tag = "R9";
      model.delete();
      repeat (2) begin @(negedge clk); compare(); end
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare();                 // R4 reset state
      rst_n = 1'b1;
      issue(1, 0, 8'h10, 2'b11, '0, "R9");
      issue(1, 1, 8'h00, 2'b11, 64'h1122334455667788, "R8");
      issue(1, 0, 8'h00, 2'b11, '0, "R10");
      for (int k = 0; k < 8; k++) issue(1, 0, 8'(k), 2'b00, '0, "R5");
      for (int k = 0; k < 8; k += 2) issue(1, 0, 8'(k), 2'b01, '0, "R6");
      issue(1, 0, 8'h00, 2'b10, '0, "R6");
      issue(1, 0, 8'h04, 2'b10, '0, "R5");
      issue(1, 1, 8'h03, 2'b00, 64'hFFFFFFFFFFFFFFAB, "R7");
      issue(1, 0, 8'h00, 2'b11, '0, "R7");
      issue(1, 1, 8'h0A, 2'b01, 64'hFFFFFFFFFFFFBEEF, "R9");
      issue(1, 0, 8'h08, 2'b11, '0, "R9");
      issue(1, 1, 8'h01, 2'b01, 64'h0, "R3");
      issue(1, 1, 8'h02, 2'b10, 64'h0, "R3");
      issue(1, 1, 8'h04, 2'b11, 64'h0, "R3");
      issue(1, 0, 8'h06, 2'b10, '0, "R3");
      issue(1, 0, 8'h00, 2'b11, '0, "R3");
      issue(1, 1, 8'h28, 2'b11, 64'hCAFEF00DDEADBEEF, "R1");
      issue(1, 1, 8'hF8, 2'b11, 64'h0102030405060708, "R1");
      issue(1, 0, 8'hFF, 2'b00, '0, "R1");
      issue(1, 0, 8'h00, 2'b11, '0, "R1");
      issue(0, 0, 8'h00, 2'b00, '0, "R4");
      do_reset();
      issue(1, 0, 8'h00, 2'b11, '0, "R9");
      issue(1, 1, 8'h16, 2'b00, 64'h5A, "R9");
      issue(1, 0, 8'h10, 2'b11, '0, "R9");
      for (int k = 0; k < 400; k++) begin
         issue(1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)),
               8'($urandom_range(0, 31)), 2'($urandom_range(0, 3)),
               {$urandom, $urandom}, "R2");
      end
      issue(0, 0, 8'h00, 2'b00, '0, "R4");
      @(negedge clk);
      compare();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule